// File: doc/BRIEF.md
# Self-Timed Port Resume Controller

This block owns the force-resume status bit of one host port and the resume signalling that goes with it. Software starts a resume by writing a 1 to the bit. The hardware also sets the bit when it sees the remote device move the line from J to K while the port is suspended. A hardware-started resume also raises a port-change flag that software clears by writing a 1 to it.

For as long as the bit is set, the block asks the transceiver to drive a full-speed K state. The block counts the resume time itself on a microsecond tick and then clears the bit without software help. Next it asks for a short single-ended-zero end-of-resume period of two low-speed bit times, and then it leaves the port idle. Writing 0 to the bit does nothing. When port power is removed, the bit and the drive requests read as 0 at once.

Top module: `port_resume_ctrl`

## Requirements
- R1: After reset, resume_rd, port_change, drive_k and drive_se0 are all 0.
- R2: A register write (wr_en=1) with wr_resume=1, while the port is idle and powered, sets resume_rd and drive_k from the next cycle. port_change does not change.
- R3: The line_state input uses the encoding J=2'b01 and K=2'b10. J in one cycle followed by K in the next, while port_suspended=1, power is on and the port is idle, starts a resume and sets port_change. SE0-to-K, K-to-J, an unsuspended port or power off start nothing.
- R4: A write with wr_resume=0 has no effect. A write of 1 during the resume or the end-of-resume period neither restarts nor lengthens the sequence.
- R5: resume_rd and drive_k stay high for exactly RESUME_US cycles in which us_tick is 1, counted from the first cycle after the start. Cycles with us_tick=0 do not count. The block then clears the bit itself.
- R6: After the bit clears, drive_se0 is high for 2*LS_BIT_CLKS clock cycles. After that, all outputs return to 0.
- R7: While port_power is 0, resume_rd, drive_k and drive_se0 read 0 in the same cycle. A power loss aborts any sequence and clears port_change.
- R8: port_change is write-1-to-clear through wr_en with wr_chg_clr=1. A hardware set in the same cycle wins over the clear.
- R9: drive_k and drive_se0 are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_power | input | 1 | Port power is on |
| port_suspended | input | 1 | Port is in the suspended state |
| line_state | input | 2 | Sampled line state (J=01, K=10, SE0=00) |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_resume | input | 1 | Write data for the force-resume bit (only 1 acts) |
| wr_chg_clr | input | 1 | Write data: 1 clears port_change |
| resume_rd | output | 1 | Read value of the force-resume bit |
| port_change | output | 1 | Port-change-detect status |
| drive_k | output | 1 | Request to drive a full-speed K state |
| drive_se0 | output | 1 | Request to drive the end-of-resume SE0 |

## Verification
A state machine stuck in the resume state shows up as drive_k staying high past the tick budget. This is seen at the port RESUME_US ticks after the start. A timer that counts clocks instead of ticks, or that misses a restart, changes the measured K length, and the bench measures that length directly. A wrong transition out of the resume state shows up within one cycle as a missing or misplaced drive_se0 window. A change flag set from the wrong source is visible on the very next cycle after a software start.

// File: rtl/resume_pkg.sv
// Shared types and line-state codes for the port resume controller.
// Assumes line_state has already been synchronised into the clk domain.
package resume_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESUME = 2'd1,
        ST_EOP    = 2'd2
    } rs_state_t;

    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;
endpackage

// File: rtl/line_jk_detect.sv
// Flags a J-to-K transition of the line state between two consecutive cycles.
// Assumes line_state is already synchronous to clk. The previous-value register
// resets to SE0, so the first cycle after reset never reports a hit.
module line_jk_detect
    import resume_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    output logic       jk_hit
);
    logic [1:0] prev_q;

    // Hold last cycle's line state
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LINE_SE0;
        else        prev_q <= line_state;
    end

    // Hit when the line was J last cycle and is K now
    always_comb jk_hit = (prev_q == LINE_J) && (line_state == LINE_K);

    // R3
    jk_prev_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jk_hit |-> ($past(line_state) == LINE_J));
endmodule

// File: rtl/resume_timer.sv
// Counts qualified events while run is high and raises done on the last one.
// Assumes LIMIT >= 1. clear and run are never high together. The count is
// zero whenever a new run begins.
module resume_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Terminal event: running, qualified, and at the last count
    always_comb done = run && tick && (cnt_q == LAST);

    // Advance on each qualified event, wrap to zero on done or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear)   cnt_q <= '0;
        else if (run && tick)  cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/port_resume_ctrl.sv
// Force-resume control for one host port. It starts resume on a software write
// of 1 or on a J-to-K line transition while the port is suspended. It drives K
// for RESUME_US microsecond ticks and then SE0 for two low-speed bit times, and
// it clears the bit itself. Assumes us_tick is a single-cycle pulse and that
// LS_BIT_CLKS is one low-speed bit time in clk cycles.
module port_resume_ctrl
    import resume_pkg::*;
#(
    parameter int RESUME_US   = 20000,
    parameter int LS_BIT_CLKS = 84
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_power,
    input  logic       port_suspended,
    input  logic [1:0] line_state,
    input  logic       us_tick,
    input  logic       wr_en,
    input  logic       wr_resume,
    input  logic       wr_chg_clr,
    output logic       resume_rd,
    output logic       port_change,
    output logic       drive_k,
    output logic       drive_se0
);
    localparam int EOP_CLKS = 2 * LS_BIT_CLKS;

    rs_state_t state_q, state_d;
    logic      jk_hit, hw_go, sw_go;
    logic      res_done, eop_done;
    logic      chg_q;

    line_jk_detect u_jk (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_state (line_state),
        .jk_hit     (jk_hit)
    );

    resume_timer #(.LIMIT(RESUME_US)) u_res_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_RESUME),
        .run   (state_q == ST_RESUME),
        .tick  (us_tick),
        .done  (res_done)
    );

    resume_timer #(.LIMIT(EOP_CLKS)) u_eop_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_EOP),
        .run   (state_q == ST_EOP),
        .tick  (1'b1),
        .done  (eop_done)
    );

    // Start conditions, accepted only from idle with power on
    always_comb begin
        hw_go = jk_hit && port_suspended && port_power && (state_q == ST_IDLE);
        sw_go = wr_en && wr_resume && port_power && (state_q == ST_IDLE);
    end

    // Next-state selection; loss of power always returns to idle
    always_comb begin
        state_d = state_q;
        if (!port_power) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (hw_go || sw_go) state_d = ST_RESUME;
                ST_RESUME: if (res_done)       state_d = ST_EOP;
                ST_EOP:    if (eop_done)       state_d = ST_IDLE;
                default:                       state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Port-change flag: hardware set wins over write-1-to-clear; power loss clears
    always_ff @(posedge clk) begin
        if (!rst_n || !port_power)   chg_q <= 1'b0;
        else if (hw_go)              chg_q <= 1'b1;
        else if (wr_en && wr_chg_clr) chg_q <= 1'b0;
    end

    // Outputs, gated by power in the same cycle
    always_comb begin
        resume_rd   = port_power && (state_q == ST_RESUME);
        drive_k     = port_power && (state_q == ST_RESUME);
        drive_se0   = port_power && (state_q == ST_EOP);
        port_change = chg_q;
    end

    // R9
    excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_k && drive_se0));

    // R7
    power_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(port_power) |-> (state_q == ST_IDLE));

    // R8
    change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_change) |-> $past(hw_go));

    // R6
    eop_after_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drive_k) && !drive_k && port_power && $past(port_power)) |-> drive_se0);

    // R4
    entry_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME && $past(state_q) != ST_RESUME) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: tb/port_resume_ctrl_test.sv
`timescale 1ns/1ps
module port_resume_ctrl_test;
    localparam int RUS = 30;
    localparam int LSB = 3;
    localparam int EOPN = 2 * LSB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pw = 1'b0, sus = 1'b0, tick = 1'b0;
    logic we = 1'b0, wres = 1'b0, wclr = 1'b0;
    logic [1:0] line = 2'b00;
    logic resume_rd, port_change, drive_k, drive_se0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    port_resume_ctrl #(.RESUME_US(RUS), .LS_BIT_CLKS(LSB)) uut (
        .clk(clk), .rst_n(rst_n), .port_power(pw), .port_suspended(sus),
        .line_state(line), .us_tick(tick), .wr_en(we), .wr_resume(wres),
        .wr_chg_clr(wclr), .resume_rd(resume_rd), .port_change(port_change),
        .drive_k(drive_k), .drive_se0(drive_se0)
    );

    // Row: pw sus we wres wclr line[1:0] tick | exp resume change k se0
    localparam logic [11:0] VEC [17] = '{
        12'b110000100000, 12'b100001000000, 12'b110000100000, 12'b111000100000,
        12'b110000000000, 12'b110001000000, 12'b110000100000, 12'b010001000000,
        12'b110000100000, 12'b110001001110, 12'b110001001110, 12'b111011001010,
        12'b111001001010, 12'b010001000000, 12'b111101001010, 12'b111100101010,
        12'b010000100000
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [3:0] exp);
        check(req, {resume_rd, port_change, drive_k, drive_se0}, exp);
    endtask

    // Called at the negedge where the start stimulus is applied; measures K and SE0 lengths
    task automatic measure(input int hold0, input int wr_at, output int klen, output int elen);
        klen = 0;
        elen = 0;
        tick = 1'b0;
        for (int i = 1; i < 400; i++) begin
            @(negedge clk);
            we = (i == wr_at);
            wres = (i == wr_at);
            tick = (i > hold0);
            if (drive_k) klen++;
            else if (drive_se0) elen++;
            else if (i > 1) break;
        end
        we = 1'b0;
        wres = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int kl, el;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outs("R1 reset", 4'b0000);

        // Table walk: start conditions, ignored writes, flag clearing, power gating
        foreach (VEC[n]) begin
            {pw, sus, we, wres, wclr, line, tick} = VEC[n][11:4];
            @(negedge clk);
            check_outs($sformatf("R2 R3 R4 R7 R8 row%0d", n), VEC[n][3:0]);
        end
        we = 0; wres = 0; wclr = 0; pw = 1; sus = 1; line = 2'b01;
        repeat (2) @(negedge clk);

        // R5/R6: software start, tick always high
        we = 1; wres = 1;
        measure(0, 0, kl, el);
        check("R5 sw K length", kl, RUS);
        check("R6 EOP length", el, EOPN);
        check_outs("R6 idle after EOP", 4'b0000);
        check("R2 no change on sw start", port_change, 0);

        // R5: ticks held low for 10 cycles extend K by 10
        @(negedge clk);
        we = 1; wres = 1;
        measure(10, 0, kl, el);
        check("R5 tick-gated K length", kl, RUS + 10);

        // R4: write of 1 mid-resume does not extend it
        @(negedge clk);
        we = 1; wres = 1;
        measure(0, 15, kl, el);
        check("R4 rewrite mid K", kl, RUS);
        check("R4 rewrite mid K eop", el, EOPN);

        // R4: write of 1 during EOP does not restart
        @(negedge clk);
        we = 1; wres = 1;
        measure(0, RUS + 2, kl, el);
        check("R4 rewrite in EOP K", kl, RUS);
        check("R4 rewrite in EOP eop", el, EOPN);
        check_outs("R4 idle after EOP write", 4'b0000);

        // R3: hardware start times out the same way and sets change
        line = 2'b01;
        @(negedge clk);
        line = 2'b10;
        measure(0, 0, kl, el);
        check("R3 hw K length", kl, RUS);
        check("R3 hw change set", port_change, 1);

        // R8: hardware set wins over a same-cycle clear
        we = 1; wclr = 1;
        @(negedge clk);
        we = 0; wclr = 0;
        check("R8 w1c", port_change, 0);
        line = 2'b01;
        @(negedge clk);
        line = 2'b10; we = 1; wclr = 1;
        @(negedge clk);
        we = 0; wclr = 0;
        check("R8 set beats clear", port_change, 1);

        // R7: power drop mid-resume gates outputs in the same cycle
        repeat (3) @(negedge clk);
        pw = 0;
        #1;
        check("R7 same-cycle resume_rd", resume_rd, 0);
        check("R7 same-cycle drive_k", drive_k, 0);
        @(negedge clk);
        check("R7 change cleared", port_change, 0);
        pw = 1;
        @(negedge clk);
        check_outs("R7 stays idle", 4'b0000);

        // R7: power drop during EOP aborts it
        tick = 1; we = 1; wres = 1;
        @(negedge clk);
        we = 0; wres = 0;
        repeat (RUS + 1) @(negedge clk);
        check("R9 EOP only", {drive_k, drive_se0}, 2'b01);
        pw = 0;
        @(negedge clk);
        pw = 1;
        @(negedge clk);
        check_outs("R7 EOP aborted", 4'b0000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule